// File: doc/BRIEF.md
# Instruction Prefetch Word Queue

This block keeps the instruction stream of a 16-bit microsequencer running. It fetches 16-bit instruction words from memory over a simple bus. The bus raises a request with an address, and the memory holds the cycle open with a wait input. Each fetched word is written into stage A and then moves to stage B, where the execution unit decodes it. When the executor signals that the instruction is complete, the word in stage B moves to stage C and stays there until the next completion. The executor can read a full 16-bit extension word from stage A, or an 8-bit operand from the low byte of stage B.

The block owns the prefetch program counter. The counter advances by one word each time a fetch is issued. With stages A and B full and the next fetch in flight, the counter therefore sits six bytes ahead of the instruction being decoded.

On a change of program flow, the counter is loaded with the target address and both stages A and B are emptied. A fetch that was already in flight finishes on the bus, and its data is then dropped. The queue then refills from the target. The executor waits on a ready flag until a new word reaches stage B.

Top module: `insn_prefetch_queue`

## Requirements
- R1: A bus cycle keeps `mem_req_o` high with a stable address from the clock it is issued. It lasts at least two clocks. Each clock in which `mem_wait_i` is high, from the second clock of the cycle onwards, adds exactly one clock. A cycle without waits or stall lasts exactly two clocks.
- R2: Bus cycles fetch consecutive word addresses, 2 bytes apart, starting at `RESET_PC` after reset. The program counter advances by 2 when a cycle is issued, so `pc_o` equals `mem_addr_o` + 2 while a cycle from the current stream is open.
- R3: A fetched word is written to stage A and then moves into stage B. `queue_ready_o` is high exactly when stage B holds a word. `ext_ready_o` is high when both stage A and stage B hold words.
- R4: When `done_i` is high and `queue_ready_o` is high, the word in stage B moves to stage C (`done_valid_o` high, `done_word_o` equal to the retired opcode) and stage A moves into stage B. When `queue_ready_o` is low, `done_i` has no effect on stage C.
- R5: Retired opcodes come from strictly consecutive word addresses within one stream, with no word lost or duplicated.
- R6: When stages A and B both hold words and a fetch from the current stream is in flight, `pc_o` equals the address of the stage B word plus 6.
- R7: `flow_chg_i` loads the program counter with `flow_tgt_i`, with bit 0 forced to zero. On that same edge it empties stages A and B, so `queue_ready_o` and `ext_ready_o` are low in the following cycle. `pc_o` then reads the target, or the target + 2 if a new cycle was issued on that edge.
- R8: A fetch in flight during a flow change completes on the bus and its data is discarded. The next bus cycle uses the target address, and the first opcode retired afterwards comes from the target.
- R9: `ext_word_o` presents the stage A word and `opb_byte_o` presents bits 7:0 of the stage B word.
- R10: If a bus cycle finishes while stages A and B are both occupied and nothing retires, the cycle is held open with the same address until stage A frees. The word is not lost.
- R11: While reset is active, `mem_req_o`, `queue_ready_o`, `ext_ready_o` and `done_valid_o` are low and `pc_o` equals `RESET_PC`.
- R12: A completion on the same edge as a flow change still moves the completing stage B word into stage C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flow_chg_i | input | 1 | Change of program flow |
| flow_tgt_i | input | AW | Target byte address of the new stream |
| done_i | input | 1 | Current instruction completes |
| mem_req_o | output | 1 | Bus cycle active |
| mem_addr_o | output | AW | Fetch byte address |
| mem_wait_i | input | 1 | Memory extends the cycle by one clock |
| mem_rdata_i | input | 16 | Fetched instruction word |
| queue_ready_o | output | 1 | Stage B holds an opcode |
| ext_ready_o | output | 1 | Stages A and B both hold words |
| opcode_o | output | 16 | Stage B word |
| opb_byte_o | output | 8 | Low byte of stage B |
| ext_word_o | output | 16 | Stage A word |
| done_valid_o | output | 1 | Stage C holds a word |
| done_word_o | output | 16 | Stage C word (last completed opcode) |
| pc_o | output | AW | Prefetch program counter |

## Verification
The bench builds the block with `AW` = 16 and `RESET_PC` = 0x0100. The memory model returns each word as its address XOR a key, so every opcode carries its own address. The bench sweeps wait counts 0 to 3 against four completion rhythms: every clock, every second clock, every third clock, and a pseudo-random pattern. It issues flow changes to odd targets, back-to-back flow changes that make a refill fetch stale, and a target just below 0xFFFF. With 16-bit addresses, that last target exercises the counter wrap within a few fetches. A long completion pause at zero wait forces the held-open cycle of R10.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int STEP   = WORD_W / 8;
  localparam int LEAD   = 3 * STEP;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_T1   = 2'd1,
    BUS_T2   = 2'd2
  } bus_st_e;
endpackage

// File: rtl/pfq_bus_ctrl.sv
module pfq_bus_ctrl
  import pfq_pkg::*;
#(
  parameter int          AW       = 16,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flow_chg_i,
  input  logic [AW-1:0] flow_tgt_i,
  input  logic          a_free_i,
  input  logic          mem_wait_i,
  input  word_t         mem_rdata_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] pc_o,
  output logic          cap_we_o,
  output word_t         cap_word_o,
  output logic [AW-1:0] cap_addr_o,
  output logic          live_o
);
  localparam logic [AW-1:0] INC = AW'(STEP);

  bus_st_e       state_q, state_d;
  logic [AW-1:0] pc_q, pc_d, addr_q, addr_d, tgt_al, issue_addr;
  logic          stale_q, stale_d;
  logic          cap_end, issue;

  assign tgt_al = flow_tgt_i & ~AW'(1);

  // end of T2: memory ready and either stale data or room in stage A
  assign cap_end    = (state_q == BUS_T2) && !mem_wait_i && (stale_q || a_free_i);
  assign issue      = (state_q == BUS_IDLE) || cap_end;
  assign issue_addr = flow_chg_i ? tgt_al : pc_q;

  always_comb begin
    state_d = state_q;
    if (issue)                  state_d = BUS_T1;
    else if (state_q == BUS_T1) state_d = BUS_T2;
  end

  always_comb begin
    pc_d    = pc_q;
    addr_d  = addr_q;
    stale_d = stale_q;
    if (issue) begin
      pc_d    = issue_addr + INC;
      addr_d  = issue_addr;
      stale_d = 1'b0;
    end else if (flow_chg_i) begin
      pc_d = tgt_al;
      if (state_q != BUS_IDLE) stale_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BUS_IDLE;
      pc_q    <= RESET_PC;
      addr_q  <= RESET_PC;
      stale_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      addr_q  <= addr_d;
      stale_q <= stale_d;
    end
  end

  assign mem_req_o  = (state_q != BUS_IDLE);
  assign mem_addr_o = addr_q;
  assign pc_o       = pc_q;
  assign cap_we_o   = cap_end && !stale_q && !flow_chg_i;
  assign cap_word_o = mem_rdata_i;
  assign cap_addr_o = addr_q;
  assign live_o     = mem_req_o && !stale_q;

  // R1: a cycle that ends was already requesting on the previous clock
  p_min_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_end |-> $past(mem_req_o));

  // R1: wait keeps the cycle open with the same address
  p_wait_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BUS_T2 && mem_wait_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R2: counter one word ahead of an open current-stream cycle
  p_pc_track_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_o |-> (pc_q == addr_q + INC));
endmodule

// File: rtl/pfq_queue.sv
module pfq_queue
  import pfq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          done_i,
  input  logic          cap_we_i,
  input  word_t         cap_word_i,
  input  logic [AW-1:0] cap_addr_i,
  output logic          a_free_o,
  output logic          a_valid_o,
  output logic          b_valid_o,
  output word_t         a_word_o,
  output word_t         b_word_o,
  output logic [AW-1:0] b_addr_o,
  output logic          c_valid_o,
  output word_t         c_word_o
);
  logic          va_q, vb_q, vc_q;
  word_t         a_q, b_q, c_q;
  logic [AW-1:0] a_addr_q, b_addr_q;
  logic          retire, a_move;

  assign retire   = done_i && vb_q;
  assign a_move   = va_q && (!vb_q || retire);
  assign a_free_o = !va_q || !vb_q || done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q     <= 1'b0;
      vb_q     <= 1'b0;
      a_q      <= '0;
      b_q      <= '0;
      a_addr_q <= '0;
      b_addr_q <= '0;
    end else if (flush_i) begin
      va_q <= 1'b0;
      vb_q <= 1'b0;
    end else begin
      if (a_move) begin
        b_q      <= a_q;
        b_addr_q <= a_addr_q;
        vb_q     <= 1'b1;
      end else if (retire) begin
        vb_q <= 1'b0;
      end
      if (cap_we_i) begin
        a_q      <= cap_word_i;
        a_addr_q <= cap_addr_i;
        va_q     <= 1'b1;
      end else if (a_move) begin
        va_q <= 1'b0;
      end
    end
  end

  // stage C captures the completing opcode even during a flush
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vc_q <= 1'b0;
      c_q  <= '0;
    end else if (retire) begin
      vc_q <= 1'b1;
      c_q  <= b_q;
    end
  end

  assign a_valid_o = va_q;
  assign b_valid_o = vb_q;
  assign a_word_o  = a_q;
  assign b_word_o  = b_q;
  assign b_addr_o  = b_addr_q;
  assign c_valid_o = vc_q;
  assign c_word_o  = c_q;

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_we_i |-> a_free_o);

  p_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!va_q && !vb_q));

  p_b_from_a_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vb_q) |-> $past(va_q));

  p_retire_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire |=> (vc_q && c_q == $past(b_q)));
endmodule

// File: rtl/insn_prefetch_queue.sv
module insn_prefetch_queue
  import pfq_pkg::*;
#(
  parameter int            AW       = 16,
  parameter logic [AW-1:0] RESET_PC = AW'(16'h0100)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flow_chg_i,
  input  logic [AW-1:0]       flow_tgt_i,
  input  logic                done_i,
  output logic                mem_req_o,
  output logic [AW-1:0]       mem_addr_o,
  input  logic                mem_wait_i,
  input  logic [WORD_W-1:0]   mem_rdata_i,
  output logic                queue_ready_o,
  output logic                ext_ready_o,
  output logic [WORD_W-1:0]   opcode_o,
  output logic [BYTE_W-1:0]   opb_byte_o,
  output logic [WORD_W-1:0]   ext_word_o,
  output logic                done_valid_o,
  output logic [WORD_W-1:0]   done_word_o,
  output logic [AW-1:0]       pc_o
);
  logic          a_free, cap_we, live, a_valid, b_valid;
  word_t         cap_word, a_word, b_word;
  logic [AW-1:0] cap_addr, b_addr, pc;

  pfq_bus_ctrl #(.AW(AW), .RESET_PC(RESET_PC)) u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flow_chg_i  (flow_chg_i),
    .flow_tgt_i  (flow_tgt_i),
    .a_free_i    (a_free),
    .mem_wait_i  (mem_wait_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .pc_o        (pc),
    .cap_we_o    (cap_we),
    .cap_word_o  (cap_word),
    .cap_addr_o  (cap_addr),
    .live_o      (live)
  );

  pfq_queue #(.AW(AW)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flow_chg_i),
    .done_i     (done_i),
    .cap_we_i   (cap_we),
    .cap_word_i (cap_word),
    .cap_addr_i (cap_addr),
    .a_free_o   (a_free),
    .a_valid_o  (a_valid),
    .b_valid_o  (b_valid),
    .a_word_o   (a_word),
    .b_word_o   (b_word),
    .b_addr_o   (b_addr),
    .c_valid_o  (done_valid_o),
    .c_word_o   (done_word_o)
  );

  assign queue_ready_o = b_valid;
  assign ext_ready_o   = a_valid && b_valid;
  assign opcode_o      = b_word;
  assign opb_byte_o    = b_word[BYTE_W-1:0];
  assign ext_word_o    = a_word;
  assign pc_o          = pc;

  // R6: six-byte lead over the decoded opcode with a full queue
  p_lead_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid && b_valid && live) |-> (pc == b_addr + AW'(LEAD)));
endmodule

// File: tb/insn_prefetch_queue_bench.sv
`timescale 1ns/1ps
module insn_prefetch_queue_bench;
  localparam logic [15:0] RPC = 16'h0100;
  localparam logic [15:0] KEY = 16'hC3A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flow_chg = 1'b0;
  logic [15:0] flow_tgt = '0;
  logic        done = 1'b0;
  logic        mem_req, mem_wait, q_rdy, x_rdy, c_vld;
  logic [15:0] mem_addr, mem_rdata, opc, xw, cw, pc;
  logic [7:0]  opb;

  always #4 clk = ~clk;

  insn_prefetch_queue #(.AW(16), .RESET_PC(RPC)) u_insn_prefetch_queue (
    .clk_i(clk), .rst_ni(rst_n), .flow_chg_i(flow_chg), .flow_tgt_i(flow_tgt),
    .done_i(done), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_wait_i(mem_wait), .mem_rdata_i(mem_rdata), .queue_ready_o(q_rdy),
    .ext_ready_o(x_rdy), .opcode_o(opc), .opb_byte_o(opb), .ext_word_o(xw),
    .done_valid_o(c_vld), .done_word_o(cw), .pc_o(pc)
  );

  // memory model: word = address ^ KEY, w_cur wait clocks per cycle
  logic [7:0] ph, w_cur, wait_cfg, last_len, last_w;
  logic       stale_m, last_stalled;
  int         starts, ends;

  assign mem_rdata = mem_addr ^ KEY;
  assign mem_wait  = mem_req && (ph != 8'd0) && (ph <= w_cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0; w_cur <= '0; stale_m <= 1'b0; starts <= 0; ends <= 0;
      last_len <= '0; last_w <= '0; last_stalled <= 1'b0;
    end else if (mem_req) begin
      if (ph != 8'd0 && !mem_wait && (stale_m || !x_rdy || done)) begin
        ends         <= ends + 1;
        last_len     <= ph + 8'd1;
        last_w       <= w_cur;
        last_stalled <= (ph != w_cur + 8'd1);
        starts       <= starts + 1;
        ph           <= '0;
        w_cur        <= wait_cfg;
        stale_m      <= 1'b0;
      end else begin
        ph <= ph + 8'd1;
        if (flow_chg) stale_m <= 1'b1;
      end
    end else begin
      starts  <= starts + 1;
      ph      <= '0;
      w_cur   <= wait_cfg;
      stale_m <= 1'b0;
    end
  end

  bit wd = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    wd = 1'b1;
  end

  int n_chk = 0, n_fail = 0;
  int seen_starts = 0, seen_ends = 0;
  logic [15:0] fetch_exp, exp_addr, pend_word, flush_tgt, sv_c;
  bit pend_c, pend_ign, pend_flush, sv_v, pend_r12;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic monitor();
    bit started = 1'b0;
    if (starts != seen_starts) begin
      seen_starts = starts;
      started = 1'b1;
      chk(mem_addr == fetch_exp, "R2 fetch address", 32'(mem_addr), 32'(fetch_exp));
      fetch_exp = fetch_exp + 16'd2;
    end
    if (ends != seen_ends) begin
      seen_ends = ends;
      chk(last_len >= 8'd2, "R1 minimum two clocks", 32'(last_len), 32'd2);
      if (!last_stalled)
        chk(last_len == last_w + 8'd2, "R1 wait extension", 32'(last_len), 32'(last_w + 8'd2));
    end
    if (pend_c) begin
      chk(c_vld && cw == pend_word, pend_r12 ? "R12 stage C on flush edge" : "R4 stage C capture",
          32'(cw), 32'(pend_word));
    end
    if (pend_ign)
      chk(c_vld == sv_v && cw == sv_c, "R4 done ignored when not ready", 32'(cw), 32'(sv_c));
    if (pend_flush) begin
      chk(!q_rdy && !x_rdy, "R7 stages emptied", 32'({q_rdy, x_rdy}), 32'd0);
      chk(pc == flush_tgt + (started ? 16'd2 : 16'd0), "R7 pc loaded", 32'(pc),
          32'(flush_tgt + (started ? 16'd2 : 16'd0)));
    end
    pend_c = 0; pend_ign = 0; pend_flush = 0; pend_r12 = 0;
    if (mem_req && !stale_m)
      chk(pc == mem_addr + 16'd2, "R2 pc ahead of bus", 32'(pc), 32'(mem_addr + 16'd2));
    if (q_rdy && x_rdy && mem_req && !stale_m)
      chk(pc == (opc ^ KEY) + 16'd6, "R6 six-byte lead", 32'(pc), 32'((opc ^ KEY) + 16'd6));
    if (x_rdy) begin
      chk((xw ^ KEY) == (opc ^ KEY) + 16'd2, "R3 R9 stage A word", 32'(xw ^ KEY), 32'((opc ^ KEY) + 16'd2));
      chk(opb == opc[7:0], "R9 low byte operand", 32'(opb), 32'(opc[7:0]));
    end
  endtask

  task automatic tick(input bit dn, input bit fl, input logic [15:0] tg);
    @(negedge clk);
    monitor();
    done = dn;
    flow_chg = fl;
    flow_tgt = tg;
    if (dn && q_rdy) begin
      chk((opc ^ KEY) == exp_addr, fl ? "R8 R5 retire order" : "R5 retire order",
          32'(opc ^ KEY), 32'(exp_addr));
      exp_addr = exp_addr + 16'd2;
      pend_c = 1; pend_word = opc; pend_r12 = fl;
    end else if (dn) begin
      pend_ign = 1; sv_v = c_vld; sv_c = cw;
    end
    if (fl) begin
      flush_tgt = tg & 16'hFFFE;
      exp_addr = flush_tgt;
      fetch_exp = flush_tgt;
      pend_flush = 1;
    end
  endtask

  logic [7:0]  lfsr = 8'hA5;
  logic [15:0] held;

  initial begin
    wait_cfg = 8'd0;
    fetch_exp = RPC; exp_addr = RPC;
    repeat (3) begin
      @(negedge clk);
      chk(!mem_req && !q_rdy && !x_rdy && !c_vld, "R11 reset outputs",
          32'({mem_req, q_rdy, x_rdy, c_vld}), 32'd0);
      chk(pc == RPC, "R11 reset pc", 32'(pc), 32'(RPC));
    end
    rst_n = 1'b1;

    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 4; p++) begin
        wait_cfg = 8'(w);
        for (int c = 0; c < 60; c++) begin
          bit fl = (c == 20) || (c == 23) || (c == 45);
          logic [15:0] tg;
          bit dn;
          if (wd) break;
          tg = (c == 45) ? 16'hFFFC :
               16'h2001 + 16'(w) * 16'h0100 + 16'(p) * 16'h0010 + 16'(c);
          if (fl)          dn = 1'b1;
          else if (p == 3) dn = lfsr[0];
          else             dn = (c % (p + 1)) == 0;
          tick(dn, fl, tg);
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
      end
    end

    // R10: no completions at zero wait, cycle held open
    wait_cfg = 8'd0;
    held = '0;
    for (int k = 0; k < 12; k++) begin
      tick(1'b0, 1'b0, 16'h0);
      if (k == 6) held = mem_addr;
      if (k == 11) begin
        chk(q_rdy && x_rdy && mem_req, "R10 held with full queue",
            32'({q_rdy, x_rdy, mem_req}), 32'd7);
        chk(mem_addr == held && mem_addr == (opc ^ KEY) + 16'd4, "R10 address held",
            32'(mem_addr), 32'((opc ^ KEY) + 16'd4));
      end
    end
    for (int k = 0; k < 40; k++) tick(1'b1, 1'b0, 16'h0);
    tick(1'b0, 1'b0, 16'h0);

    if (wd) begin
      n_chk++; n_fail++;
      $display("FAIL R5 watchdog expired act=%0d exp=%0d", 1, 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule